// File: doc/BRIEF.md
# Strided Block Address Generator

This block produces the per-beat addresses for one side of a DMA transfer. A start pulse loads a base address, a 32-bit configuration word and a total byte count. From the next cycle the block issues one beat per accepted handshake (`beat_valid` and `beat_ready` both high). Each beat carries an address, a burst flag and a last flag.

The configuration word selects four things:

- the beat width: 1, 2, 4 or 8 bytes;
- how the address moves: up, down, held, or up with the burst flag set;
- a block size in bytes;
- a stride in bytes.

In the two upward modes, once a full block of bytes has been issued, the stride is added on top of the normal step. This skips a gap before the next block starts.

The generator stops on the beat that uses up the remaining byte count. It then stays idle until it is started again. Bus protocol, data movement and descriptor parsing belong to the neighbouring logic.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `beat_burst` are all low.
- R2: A start pulse that arrives while the block is idle with a nonzero byte count is accepted. In the next cycle `beat_valid` is high and `beat_addr` equals the base address.
- R3: The beat width code gives the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R4: In increment mode (movement code 0) the address rises by the beat size after each accepted beat.
- R5: In increment or burst mode with a nonzero block size, the stride is added to the normal step on the beat that brings the bytes issued in the current block to the block size or past it. The block count then restarts. A block size of 0 disables skipping, and a stride of 0 keeps the blocks contiguous.
- R6: In decrement mode (movement code 1) the address falls by the beat size after each accepted beat, and the stride is not used.
- R7: In static mode (movement code 2) every beat uses the base address.
- R8: In burst mode (movement code 3) the addresses follow increment mode and `beat_burst` is high on every beat. In the other modes `beat_burst` stays low.
- R9: `beat_last` is high on the beat where the remaining byte count is at most the beat size. After that beat is accepted, `beat_valid` is low in the next cycle.
- R10: While `beat_valid` is high and `beat_ready` is low, `beat_addr`, `beat_last` and `beat_burst` hold their values.
- R11: A start pulse is ignored while a transfer is running, and also when the byte count is zero.
- R12: Field positions in the configuration word:
  - bits 31:30 hold the beat width code;
  - bits 29:28 hold the movement code;
  - bits 27:14 hold the block size;
  - bits 13:0 hold the stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the inputs and begin a transfer when idle |
| base_addr | input | ADDR_W | First address of the transfer |
| cfg_word | input | 2*FLD_W+4 | Beat width, movement mode, block size and stride |
| byte_count | input | CNT_W | Total bytes to cover |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | ADDR_W | Address of the presented beat |
| beat_burst | output | 1 | The beat belongs to a burst-mode transfer |
| beat_last | output | 1 | Final beat of the transfer |

## Verification
- Timing of each result:
  - The first beat appears exactly one cycle after the clock edge that captures the start pulse.
  - Each later address appears one cycle after the edge that accepts the previous beat.
  - `beat_valid` falls one cycle after the final handshake.
- How the bench keeps to this timing:
  - It drives inputs and samples outputs on the falling clock edge.
  - It advances its reference address and byte count only for a cycle in which it drove `beat_ready` high while a beat was presented.
- Stall cycles:
  - Stall cycles are mixed into every transfer.
  - The reference does not move during a stall, so the value it expects there is the value the design must hold.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    MV_INC   = 2'd0,
    MV_DEC   = 2'd1,
    MV_HOLD  = 2'd2,
    MV_BURST = 2'd3
  } move_e;

  // Beat width code to bytes: 1, 2, 4, 8.
  function automatic logic [3:0] code_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic moves_up(input move_e mv);
    return (mv == MV_INC) || (mv == MV_BURST);
  endfunction
endpackage

// File: rtl/sag_cfg_decode.sv
module sag_cfg_decode
  import sag_pkg::*;
#(
  parameter int FLD_W = 14,
  localparam int CFG_W = 2*FLD_W + 4
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic [1:0]       size_code,
  output move_e            move,
  output logic [FLD_W-1:0] blk_len,
  output logic [FLD_W-1:0] stride
);
  // Layout from the top: width code, movement code, block size, stride.
  assign size_code = cfg_word[CFG_W-1 -: 2];
  assign move      = move_e'(cfg_word[CFG_W-3 -: 2]);
  assign blk_len   = cfg_word[2*FLD_W-1 : FLD_W];
  assign stride    = cfg_word[FLD_W-1 : 0];
endmodule

// File: rtl/sag_count.sv
module sag_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [3:0]       bytes,
  output logic [CNT_W-1:0] remaining,
  output logic             last_beat
);
  logic [CNT_W-1:0] rem_q;

  function automatic logic [CNT_W-1:0] rem_after(input logic [CNT_W-1:0] r,
                                                 input logic [3:0] b);
    if (r <= CNT_W'(b)) return '0;
    return r - CNT_W'(b);
  endfunction

  assign last_beat = (rem_q <= CNT_W'(bytes));
  assign remaining = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (step) rem_q <= rem_after(rem_q, bytes);
  end

  // R9
  last_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_beat && !load) |=> (rem_q == '0));
endmodule

// File: rtl/sag_addr_step.sv
module sag_addr_step
  import sag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FLD_W  = 14,
  localparam int ACC_W = FLD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  move_e             move,
  input  logic [FLD_W-1:0]  blk_len,
  input  logic [FLD_W-1:0]  stride,
  input  logic [3:0]        bytes,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              block_wrap
);
  logic [ADDR_W-1:0] addr_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_sum;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input move_e mv,
                                                  input logic [3:0] b,
                                                  input logic wrap,
                                                  input logic [FLD_W-1:0] s);
    case (mv)
      MV_DEC:  return a - ADDR_W'(b);
      MV_HOLD: return a;
      default: return a + ADDR_W'(b) + (wrap ? ADDR_W'(s) : '0);
    endcase
  endfunction

  assign acc_sum    = acc_q + ACC_W'(bytes);
  assign block_wrap = moves_up(move) && (blk_len != '0) && (acc_sum >= ACC_W'(blk_len));
  assign addr       = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      acc_q  <= '0;
    end else if (load) begin
      addr_q <= base;
      acc_q  <= '0;
    end else if (step) begin
      addr_q <= next_addr(addr_q, move, bytes, block_wrap, stride);
      acc_q  <= block_wrap ? '0 : acc_sum;
    end
  end

  // R7
  hold_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && move == MV_HOLD) |=> (addr_q == $past(addr_q)));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(addr_q));
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 22,
  parameter int FLD_W  = 14,
  localparam int CFG_W = 2*FLD_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_burst,
  output logic              beat_last
);
  logic             active_q;
  logic [1:0]       size_d, size_q;
  move_e            move_d, move_q;
  logic [FLD_W-1:0] blk_d, blk_q, stride_d, stride_q;
  logic [3:0]       bytes_w;
  logic [CNT_W-1:0] rem_w;
  logic             last_w, wrap_w;

  // Named events for the checks.
  logic accept, step, finish;

  sag_cfg_decode #(.FLD_W(FLD_W)) u_dec (
    .cfg_word(cfg_word), .size_code(size_d), .move(move_d),
    .blk_len(blk_d), .stride(stride_d)
  );

  assign accept  = start && !active_q && (byte_count != '0);
  assign step    = active_q && beat_ready;
  assign finish  = step && last_w;
  assign bytes_w = code_to_bytes(size_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      size_q   <= '0;
      move_q   <= MV_INC;
      blk_q    <= '0;
      stride_q <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      size_q   <= size_d;
      move_q   <= move_d;
      blk_q    <= blk_d;
      stride_q <= stride_d;
    end else if (finish) begin
      active_q <= 1'b0;
    end
  end

  sag_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(byte_count),
    .step(step), .bytes(bytes_w), .remaining(rem_w), .last_beat(last_w)
  );

  sag_addr_step #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(base_addr),
    .move(move_q), .blk_len(blk_q), .stride(stride_q), .bytes(bytes_w),
    .step(step), .addr(beat_addr), .block_wrap(wrap_w)
  );

  assign beat_valid = active_q;
  assign beat_last  = active_q && last_w;
  assign beat_burst = active_q && (move_q == MV_BURST);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (beat_valid && beat_addr == $past(base_addr)));

  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !beat_valid);

  // R9
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (rem_w != '0));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) &&
                                     $stable(beat_last) && $stable(beat_burst)));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !step) |=> $stable(rem_w));

  // R5
  wrap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap_w) |=> (beat_addr == $past(beat_addr) + ADDR_W'($past(bytes_w)) +
                                       ADDR_W'($past(stride_q))));
endmodule

// File: tb/stride_addr_gen_tb_top.sv
module stride_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int CW = 22;

  typedef struct packed {
    logic [1:0]  sz;
    logic [1:0]  mv;
    logic [13:0] blk;
    logic [13:0] str;
    logic [31:0] base;
    logic [21:0] cnt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd0, 14'd16, 14'd8,   32'h1000, 22'd40},
    '{2'd0, 2'd1, 14'd0,  14'd0,   32'h0200, 22'd6},
    '{2'd1, 2'd2, 14'd0,  14'd0,   32'h0300, 22'd10},
    '{2'd3, 2'd3, 14'd32, 14'd64,  32'h4000, 22'd96},
    '{2'd2, 2'd0, 14'd0,  14'd100, 32'h0500, 22'd20},
    '{2'd2, 2'd0, 14'd0,  14'd0,   32'h0600, 22'd6},
    '{2'd0, 2'd0, 14'd3,  14'd2,   32'h0010, 22'd9},
    '{2'd2, 2'd0, 14'd8,  14'd0,   32'h0700, 22'd24}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [31:0]   cfg_word = '0;
  logic [CW-1:0] byte_count = '0;
  logic          beat_ready = 1'b0;
  logic          beat_valid, beat_burst, beat_last;
  logic [AW-1:0] beat_addr;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  stride_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .cfg_word(cfg_word), .byte_count(byte_count), .beat_ready(beat_ready),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_burst(beat_burst),
    .beat_last(beat_last)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] m_addr;
    int acc, rem, nb, beat, guard;
    string tag;
    logic stalled;
    nb = 1 << v.sz;                       // R3
    m_addr = v.base; acc = 0; rem = int'(v.cnt); beat = 0; guard = 0; stalled = 1'b0;
    case (v.mv)
      2'd0:    tag = (v.blk != 0) ? "R5 addr" : "R4 addr";
      2'd1:    tag = "R6 addr";
      2'd2:    tag = "R7 addr";
      default: tag = "R8 addr";
    endcase
    @(negedge clk);
    base_addr = v.base;
    cfg_word = {v.sz, v.mv, v.blk, v.str}; // R12 field order
    byte_count = v.cnt; start = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R2 first valid", beat_valid, 1);
    while (rem > 0 && guard < 1000) begin
      guard++;
      check(stalled ? "R10 addr" : tag, beat_addr, m_addr);
      check("R9 last", beat_last, (rem <= nb));
      check("R8 R12 burst", beat_burst, (v.mv == 2'd3));
      beat_ready = (beat % 3) != 2;
      stalled = !beat_ready;
      if (beat_ready) begin
        if (v.mv == 2'd0 || v.mv == 2'd3) begin
          acc += nb;
          if (v.blk != 0 && acc >= int'(v.blk)) begin
            m_addr = m_addr + nb + v.str; acc = 0;
          end else m_addr = m_addr + nb;
        end else if (v.mv == 2'd1) m_addr = m_addr - nb;
        rem = (rem <= nb) ? 0 : rem - nb;
      end
      beat++;
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check("R9 idle after last", beat_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int beats;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", beat_valid, 0);
    check("R1 last", beat_last, 0);
    check("R1 burst", beat_burst, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: zero byte count is ignored
    @(negedge clk);
    cfg_word = {2'd2, 2'd0, 28'd0}; base_addr = 32'h900; byte_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 zero count", beat_valid, 0);

    // R11: start while running is ignored
    cfg_word = {2'd2, 2'd0, 28'd0}; base_addr = 32'h800; byte_count = 22'd16; start = 1'b1;
    @(negedge clk);
    base_addr = 32'h999; byte_count = 22'd8;
    @(negedge clk);
    start = 1'b0;
    check("R11 busy start addr", beat_addr, 32'h800);
    beat_ready = 1'b1;
    beats = 0;
    for (int k = 0; k < 20 && beat_valid; k++) begin
      beats++;
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check("R11 busy start beats", beats, 4);
    check("R9 final idle", beat_valid, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule